// File: doc/BRIEF.md
# Reconfigurable Lookup-Table Memory

Two 16-bit storage arrays, A and B, are shared by five operating shapes chosen at run time by a 3-bit mode input. The arrays can serve as two separate 16x1 RAMs, one 16x2 RAM, one 32x1 RAM, or a 16x1 dual-port RAM in which array B shadows array A and has its own read address. They can also serve as a pair of 16-stage shift registers with an addressable output stage, which gives a programmable delay line. Writes and shifts happen on the rising clock edge. Reads are combinational from the address.

Switching the mode changes how the arrays are written and read. It never changes what they hold, so data written in one shape can be read back in another. An active-low asynchronous reset clears both arrays.

Top module: `lut_mem_cfg`

## Requirements
- R1: Reset (rst_n low) clears every bit of both arrays, so every read in modes 0 to 4 returns 2'b00 afterwards.
- R2: Mode 3'd0: we[0] writes wdata[0] into A[addr[3:0]], and we[1] independently writes wdata[1] into B[addr[3:0]]; rdata[0]=A[addr[3:0]], rdata[1]=B[addr[3:0]].
- R3: Mode 3'd1: we[0] writes wdata[1:0] as one word (bit 0 into A, bit 1 into B) at addr[3:0]; we[1] has no effect; reads are as in R2.
- R4: Mode 3'd2: addr[4]=0 selects A and addr[4]=1 selects B; we[0] writes wdata[0] into the selected array at addr[3:0]; rdata[0] is the selected bit and rdata[1]=0.
- R5: Mode 3'd3: we[0] writes wdata[0] into both A[addr[3:0]] and B[addr[3:0]]; rdata[0]=A[addr[3:0]] and rdata[1]=B[raddr].
- R6: Reads are combinational; a read of the location being written returns the old value until the clock edge.
- R7: Mode 3'd4: we[0] shifts both arrays by one stage; stage 0 of A takes wdata[0], stage 0 of B takes wdata[1], and stage k takes the old stage k-1.
- R8: In mode 3'd4, addr[3:0]=t puts stage t on rdata (bit 0 from A, bit 1 from B), so a bit appears after t+1 enabled shifts.
- R9: A change of mode does not alter the stored contents.
- R10: Modes 3'd5 to 3'd7 write nothing, and rdata=2'b00 in those modes.
- R11: With we=2'b00, no mode changes the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and shifts happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset that clears both arrays |
| mode | input | 3 | Selects the operating shape (0 to 4; 5 to 7 idle) |
| we | input | 2 | Write or shift enables |
| addr | input | 5 | Write and read address; bit 4 selects the array in mode 2; tap in mode 4 |
| wdata | input | 2 | Write data or shift-in bits |
| raddr | input | 4 | Independent read address for mode 3 |
| rdata | output | 2 | Combinational read data |

## Verification
The bench builds the block at its default depth of 16. At that depth it can sweep every address of every shape, every read-address pairing in dual-port mode, and every shift tap against every delay. A behavioural model of the two arrays runs beside the design. It is driven by random addresses, random enables and back-to-back writes to the same location, and its contents are carried from one mode to the next. The read-before-edge case and the three unused mode codes are checked explicitly.

// File: rtl/lut_mem_cfg.sv
module lut_mem_cfg #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode,
  input  logic [1:0]               we,
  input  logic [$clog2(DEPTH):0]   addr,
  input  logic [1:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [1:0]               rdata
);
  localparam int AW = $clog2(DEPTH);

  localparam logic [2:0] M_DUAL1  = 3'd0;
  localparam logic [2:0] M_WIDE   = 3'd1;
  localparam logic [2:0] M_DEEP   = 3'd2;
  localparam logic [2:0] M_DPORT  = 3'd3;
  localparam logic [2:0] M_SHIFT  = 3'd4;

  logic [DEPTH-1:0] arr_a, arr_b;
  logic [AW-1:0]    idx;
  logic             bank;

  assign idx  = addr[AW-1:0];
  assign bank = addr[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_a <= '0;
      arr_b <= '0;
    end else begin
      case (mode)
        M_DUAL1: begin
          if (we[0]) arr_a[idx] <= wdata[0];
          if (we[1]) arr_b[idx] <= wdata[1];
        end
        M_WIDE: if (we[0]) begin
          arr_a[idx] <= wdata[0];
          arr_b[idx] <= wdata[1];
        end
        M_DEEP: if (we[0]) begin
          if (bank) arr_b[idx] <= wdata[0];
          else      arr_a[idx] <= wdata[0];
        end
        M_DPORT: if (we[0]) begin
          arr_a[idx] <= wdata[0];
          arr_b[idx] <= wdata[0];
        end
        M_SHIFT: if (we[0]) begin
          arr_a <= {arr_a[DEPTH-2:0], wdata[0]};
          arr_b <= {arr_b[DEPTH-2:0], wdata[1]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_DUAL1, M_WIDE, M_SHIFT: rdata = {arr_b[idx], arr_a[idx]};
      M_DEEP:  rdata = {1'b0, bank ? arr_b[idx] : arr_a[idx]};
      M_DPORT: rdata = {arr_b[raddr], arr_a[idx]};
      default: rdata = 2'b00;
    endcase
  end

  // R3: a word write lands in both arrays at the addressed location
  p_word_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WIDE && we[0]) |=>
      (arr_a[$past(idx)] == $past(wdata[0]) && arr_b[$past(idx)] == $past(wdata[1])));

  // R5: dual-port writes keep the shadow array equal at that location
  p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DPORT && we[0]) |=> (arr_a[$past(idx)] == arr_b[$past(idx)]));

  // R7: shift enters at stage 0 and moves every stage up by one
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SHIFT && we[0]) |=>
      (arr_a[0] == $past(wdata[0]) && arr_b[0] == $past(wdata[1]) &&
       arr_a[DEPTH-1:1] == $past(arr_a[DEPTH-2:0]) &&
       arr_b[DEPTH-1:1] == $past(arr_b[DEPTH-2:0])));

  // R10: idle mode codes leave the arrays untouched
  p_idle_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_SHIFT) |=> ($stable(arr_a) && $stable(arr_b)));

  // R11: no enable, no change
  p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we == 2'b00) |=> ($stable(arr_a) && $stable(arr_b)));

  // R4: the deep shape never drives the upper data bit
  p_deep_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DEEP) |-> (rdata[1] == 1'b0));
endmodule

// File: tb/lut_mem_cfg_tb.sv
module lut_mem_cfg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic [1:0] we;
  logic [4:0] addr;
  logic [1:0] wdata;
  logic [3:0] raddr;
  logic [1:0] rdata;

  int checks = 0;
  int failures = 0;
  logic [15:0] ma, mb;

  always #4 clk = ~clk;

  lut_mem_cfg u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .we(we), .addr(addr),
                     .wdata(wdata), .raddr(raddr), .rdata(rdata));

  function automatic logic [1:0] exp_rd(logic [2:0] md, logic [4:0] a, logic [3:0] ra);
    case (md)
      3'd0, 3'd1, 3'd4: return {mb[a[3:0]], ma[a[3:0]]};
      3'd2: return {1'b0, a[4] ? mb[a[3:0]] : ma[a[3:0]]};
      3'd3: return {mb[ra], ma[a[3:0]]};
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b (mode=%0d addr=%0d raddr=%0d)", tag, got, exp, mode, addr, raddr);
    end
  endtask

  task automatic cyc(logic [2:0] md, logic [1:0] w, logic [4:0] a, logic [1:0] d);
    @(negedge clk);
    mode = md; we = w; addr = a; wdata = d;
    @(posedge clk);
    case (md)
      3'd0: begin if (w[0]) ma[a[3:0]] = d[0]; if (w[1]) mb[a[3:0]] = d[1]; end
      3'd1: if (w[0]) begin ma[a[3:0]] = d[0]; mb[a[3:0]] = d[1]; end
      3'd2: if (w[0]) begin if (a[4]) mb[a[3:0]] = d[0]; else ma[a[3:0]] = d[0]; end
      3'd3: if (w[0]) begin ma[a[3:0]] = d[0]; mb[a[3:0]] = d[0]; end
      3'd4: if (w[0]) begin ma = {ma[14:0], d[0]}; mb = {mb[14:0], d[1]}; end
      default: ;
    endcase
  endtask

  task automatic rd(string tag, logic [2:0] md, logic [4:0] a, logic [3:0] ra);
    @(negedge clk);
    mode = md; we = 2'b00; addr = a; raddr = ra;
    #1 chk(tag, rdata, exp_rd(md, a, ra));
  endtask

  task automatic rand_writes(logic [2:0] md, int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = $urandom;
      // every fourth write repeats the previous address back to back
      cyc(md, r[1:0] | ((md == 3'd0) ? 2'b00 : 2'b01),
          (i % 4 == 3) ? addr : r[8:4], r[10:9]);
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; we = 2'b00; addr = '0; wdata = '0; raddr = '0;
    ma = '0; mb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 16; a++) rd("R1", 3'd1, 5'(a), 4'd0);

    rand_writes(3'd0, 48);
    for (int a = 0; a < 16; a++) rd("R2", 3'd0, 5'(a), 4'd0);

    rand_writes(3'd1, 48);
    cyc(3'd1, 2'b10, 5'd3, ~exp_rd(3'd1, 5'd3, 4'd0));
    for (int a = 0; a < 16; a++) rd("R3", 3'd1, 5'(a), 4'd0);

    rand_writes(3'd2, 64);
    for (int a = 0; a < 32; a++) rd("R4", 3'd2, 5'(a), 4'd0);

    rand_writes(3'd3, 48);
    for (int a = 0; a < 16; a++)
      for (int r = 0; r < 16; r++) rd("R5", 3'd3, 5'(a), 4'(r));

    for (int a = 0; a < 16; a++) rd("R9", 3'd0, 5'(a), 4'd0);

    for (int a = 0; a < 8; a++) begin
      logic [1:0] old;
      old = exp_rd(3'd1, 5'(a), 4'd0);
      @(negedge clk);
      mode = 3'd1; we = 2'b01; addr = 5'(a); wdata = ~old;
      #1 chk("R6 read before edge", rdata, old);
      @(posedge clk);
      ma[a] = ~old[0]; mb[a] = ~old[1];
      rd("R6 read after edge", 3'd1, 5'(a), 4'd0);
    end

    for (int i = 0; i < 20; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(3'd4, 2'b01, r[4:0], r[6:5]);
    end
    for (int t = 0; t < 16; t++) rd("R7", 3'd4, 5'(t), 4'd0);

    for (int i = 0; i < 16; i++) cyc(3'd4, 2'b01, 5'd0, 2'b00);
    cyc(3'd4, 2'b01, 5'd0, 2'b11);
    for (int k = 0; k < 16; k++) begin
      for (int t = 0; t < 16; t++) begin
        @(negedge clk);
        mode = 3'd4; we = 2'b00; addr = 5'(t);
        #1 chk("R8 tap delay", rdata, (t == k) ? 2'b11 : 2'b00);
      end
      cyc(3'd4, 2'b01, 5'd0, 2'b00);
    end

    rand_writes(3'd1, 32);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(3'(i % 5), 2'b00, r[4:0], r[6:5]);
    end
    for (int a = 0; a < 16; a++) rd("R11", 3'd1, 5'(a), 4'd0);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      mode = 3'd5 + 3'(i % 3); we = 2'b11; addr = r[4:0]; wdata = r[6:5]; raddr = r[10:7];
      #1 chk("R10 idle output", rdata, 2'b00);
      @(posedge clk);
    end
    for (int a = 0; a < 16; a++) rd("R10 contents kept", 3'd1, 5'(a), 4'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule